// File: doc/BRIEF.md
# Sampling Converter Bus Interface Controller

This block is the digital front of a two-step sampling converter, built so that a processor can treat the converter as a single memory location. It qualifies an active-low sample strobe and an active-low read strobe with an active-low chip select. It captures a channel number for the conversion core and runs a clock-counted coarse/fine conversion sequence. When the fine phase ends it latches the core's result, pulls an active-low interrupt low, and presents the stored word on a data bus. That bus is driven only while a qualified read is held.

Two interface modes are chosen by a strap input. In the strobe-timed mode the sample strobe's low time is the coarse phase, and its release starts a fixed-length fine phase. In the read-combined mode the sample and read strobes are wired together. A single falling strobe starts a fully timer-driven coarse and fine sequence, and the bus, driven throughout, keeps showing the previous result until the interrupt falls. The analog sampling, ladders and comparators sit outside the block; the core simply offers `core_data` for the channel on `chan_sel_o`.

Top module: `adc_bus_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the block sets `int_n` to 1, `bus_drive` to 0, `bus_data` to 0, `chan_sel_o` to 0, and clears `overrun` and `sample_err`.
- R2: While `cs_n` is high, `sh_n` and `rd_n` have no effect: no conversion starts, the bus is not driven, and `int_n` does not change.
- R3: The channel is captured from `chsel` only at the edge that first samples a qualified low on `sh_n` (`cs_n` and `sh_n` both low) while idle. Codes 0, 1, 2 and 3 select channels 0, 1, 2 and 3. With NUM_CH = 2 only `chsel[0]` is used and the upper bit of `chan_sel_o` stays 0. The channel stays unchanged during a conversion.
- R4: In strobe-timed mode (`mode2` = 0), the fine phase starts at the first edge that samples the strobe released. `int_n` falls and the new result appears on `bus_data` FINE_CYC edges later.
- R5: In read-combined mode (`mode2` = 1), `int_n` falls and the result is latched COARSE_CYC + FINE_CYC edges after the edge that samples the strobe fall, whatever the strobe does afterwards.
- R6: `int_n`, once low, returns to 1 at the edge that first samples the qualified read released after being low. A latch in the same cycle keeps it low.
- R7: `bus_drive` equals the qualified read (`cs_n` and `rd_n` both low) sampled at the previous edge.
- R8: In read-combined mode the driven bus carries the previous result for the whole conversion. The new word appears at the same edge at which `int_n` falls.
- R9: In strobe-timed mode, if fewer than MIN_SH consecutive edges sample the sample strobe low before its release, `sample_err` is set and stays set until reset. The conversion still completes.
- R10: A qualified sample strobe fall while a conversion is running is ignored, leaving channel and completion time unchanged. It sets `overrun`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode2 | input | 1 | Interface strap: 0 strobe-timed, 1 read-combined |
| cs_n | input | 1 | Active-low chip select |
| sh_n | input | 1 | Active-low sample strobe |
| rd_n | input | 1 | Active-low read strobe |
| chsel | input | 2 | Channel number |
| core_data | input | DATA_W | Result offered by the conversion core |
| chan_sel_o | output | 2 | Captured channel for the core |
| int_n | output | 1 | Active-low end-of-conversion interrupt |
| bus_data | output | DATA_W | Stored result for the bus pads |
| bus_drive | output | 1 | Output enable for the bus pads (high means driven, low means high impedance) |
| overrun | output | 1 | Sticky flag: strobe during a conversion |
| sample_err | output | 1 | Sticky flag: sample strobe held too briefly |

## Verification
Every strobe is seen one edge after it is driven. A read therefore changes `bus_drive` one edge later, a release of the read raises `int_n` one edge later, and a result lands FINE_CYC edges after the edge that sees a strobe-timed release, or COARSE_CYC + FINE_CYC edges after the edge that sees a read-combined fall. The bench's behavioural model advances on each rising edge from the same sampled inputs. All outputs are compared at the following falling edge, so each comparison lands in the cycle the value is due. Directed checks also count edges from the driven stimulus to the interrupt fall and compare against these counts plus the one sampling edge.

// File: rtl/adc_bus_pkg.sv
package adc_bus_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SAMPLE = 2'd1,
    PH_COARSE = 2'd2,
    PH_FINE   = 2'd3
  } phase_e;

endpackage

// File: rtl/strobe_qual.sv
module strobe_qual (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sh_n,
  input  logic rd_n,
  output logic sh_act,
  output logic sh_fall,
  output logic rd_act,
  output logic rd_rise
);

  logic sh_q;
  logic rd_q;

  // chip select gates both strobes
  assign sh_act  = ~cs_n & ~sh_n;
  assign rd_act  = ~cs_n & ~rd_n;
  assign sh_fall = sh_act & ~sh_q;
  assign rd_rise = ~rd_act & rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q <= 1'b0;
      rd_q <= 1'b0;
    end else begin
      sh_q <= sh_act;
      rd_q <= rd_act;
    end
  end

endmodule

// File: rtl/conv_seq.sv
module conv_seq
  import adc_bus_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int MIN_SH     = 50,
  parameter int COARSE_CYC = 50,
  parameter int FINE_CYC   = 70
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       mode2,
  input  logic       sh_act,
  input  logic       sh_fall,
  input  logic [1:0] chsel,
  output logic       busy,
  output logic       latch,
  output logic [1:0] chan,
  output logic       overrun,
  output logic       sample_err
);

  localparam int MAX_A = (MIN_SH > COARSE_CYC) ? MIN_SH : COARSE_CYC;
  localparam int MAX_C = (MAX_A > FINE_CYC) ? MAX_A : FINE_CYC;
  localparam int CNT_W = $clog2(MAX_C + 1);
  localparam logic [CNT_W-1:0] MIN_V    = CNT_W'(MIN_SH);
  localparam logic [CNT_W-1:0] COARSE_L = CNT_W'(COARSE_CYC - 1);
  localparam logic [CNT_W-1:0] FINE_L   = CNT_W'(FINE_CYC - 1);

  phase_e           ph;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       chan_in;

  generate
    if (NUM_CH >= 4) begin : g_ch4
      assign chan_in = chsel;
    end else if (NUM_CH == 2) begin : g_ch2
      assign chan_in = {1'b0, chsel[0]};
    end else begin : g_ch1
      assign chan_in = 2'b00;
    end
  endgenerate

  assign busy  = (ph != PH_IDLE);
  assign latch = (ph == PH_FINE) && (cnt == FINE_L);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph         <= PH_IDLE;
      cnt        <= '0;
      chan       <= 2'b00;
      overrun    <= 1'b0;
      sample_err <= 1'b0;
    end else begin
      if (sh_fall && ph != PH_IDLE) overrun <= 1'b1;
      case (ph)
        PH_IDLE: begin
          if (sh_fall) begin
            chan <= chan_in;
            if (mode2) begin
              ph  <= PH_COARSE;
              cnt <= '0;
            end else begin
              ph  <= PH_SAMPLE;
              cnt <= CNT_W'(1);
            end
          end
        end
        PH_SAMPLE: begin
          if (sh_act) begin
            if (cnt < MIN_V) cnt <= cnt + 1'b1;
          end else begin
            if (cnt < MIN_V) sample_err <= 1'b1;
            ph  <= PH_FINE;
            cnt <= '0;
          end
        end
        PH_COARSE: begin
          if (cnt == COARSE_L) begin
            ph  <= PH_FINE;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_FINE: begin
          if (cnt == FINE_L) begin
            ph  <= PH_IDLE;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/result_port.sv
module result_port #(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              latch,
  input  logic [DATA_W-1:0] core_data,
  input  logic              rd_act,
  input  logic              rd_rise,
  output logic              int_n,
  output logic [DATA_W-1:0] bus_data,
  output logic              bus_drive
);

  always_ff @(posedge clk) begin
    if (rst) begin
      int_n     <= 1'b1;
      bus_data  <= '0;
      bus_drive <= 1'b0;
    end else begin
      bus_drive <= rd_act;
      if (latch) begin
        bus_data <= core_data;
        int_n    <= 1'b0;
      end else if (rd_rise) begin
        int_n <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/adc_bus_ctrl.sv
module adc_bus_ctrl #(
  parameter int DATA_W     = 10,
  parameter int NUM_CH     = 4,
  parameter int MIN_SH     = 50,
  parameter int COARSE_CYC = 50,
  parameter int FINE_CYC   = 70
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode2,
  input  logic              cs_n,
  input  logic              sh_n,
  input  logic              rd_n,
  input  logic [1:0]        chsel,
  input  logic [DATA_W-1:0] core_data,
  output logic [1:0]        chan_sel_o,
  output logic              int_n,
  output logic [DATA_W-1:0] bus_data,
  output logic              bus_drive,
  output logic              overrun,
  output logic              sample_err
);

  logic sh_act;
  logic sh_fall;
  logic rd_act;
  logic rd_rise;
  logic busy;
  logic latch;

  strobe_qual u_qual (
    .clk     (clk),
    .rst     (rst),
    .cs_n    (cs_n),
    .sh_n    (sh_n),
    .rd_n    (rd_n),
    .sh_act  (sh_act),
    .sh_fall (sh_fall),
    .rd_act  (rd_act),
    .rd_rise (rd_rise)
  );

  conv_seq #(
    .NUM_CH     (NUM_CH),
    .MIN_SH     (MIN_SH),
    .COARSE_CYC (COARSE_CYC),
    .FINE_CYC   (FINE_CYC)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .mode2      (mode2),
    .sh_act     (sh_act),
    .sh_fall    (sh_fall),
    .chsel      (chsel),
    .busy       (busy),
    .latch      (latch),
    .chan       (chan_sel_o),
    .overrun    (overrun),
    .sample_err (sample_err)
  );

  result_port #(
    .DATA_W (DATA_W)
  ) u_res (
    .clk       (clk),
    .rst       (rst),
    .latch     (latch),
    .core_data (core_data),
    .rd_act    (rd_act),
    .rd_rise   (rd_rise),
    .int_n     (int_n),
    .bus_data  (bus_data),
    .bus_drive (bus_drive)
  );

endmodule

// File: rtl/adc_bus_ctrl_chk.sv
module adc_bus_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       cs_n,
  input logic       rd_n,
  input logic       int_n,
  input logic       bus_drive,
  input logic       busy,
  input logic       overrun,
  input logic       sample_err,
  input logic [1:0] chan_sel_o
);

  logic rd_on;
  assign rd_on = !cs_n && !rd_n;

  // R4 R5
  int_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(int_n) |-> $past(busy));

  // R6
  int_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(int_n) |-> (!$past(rd_on) && $past(rd_on, 2)));

  // R7
  bus_drive_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (bus_drive == $past(rd_on)));

  // R3
  chan_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $past(busy) |-> $stable(chan_sel_o));

  // R9
  sample_err_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sample_err) |-> $past(busy));

  // R10
  overrun_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> $past(busy));

endmodule

bind adc_bus_ctrl adc_bus_ctrl_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .cs_n       (cs_n),
  .rd_n       (rd_n),
  .int_n      (int_n),
  .bus_drive  (bus_drive),
  .busy       (busy),
  .overrun    (overrun),
  .sample_err (sample_err),
  .chan_sel_o (chan_sel_o)
);

// File: tb/adc_bus_ctrl_test.sv
`timescale 1ns/1ps
module adc_bus_ctrl_test;

  localparam int DW = 10;
  localparam int MS = 4;
  localparam int CC = 6;
  localparam int FC = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst = 1'b1;
  logic          mode2 = 1'b0;
  logic          cs_n = 1'b1;
  logic          sh_n = 1'b1;
  logic          rd_n = 1'b1;
  logic [1:0]    chsel = 2'd0;
  logic [DW-1:0] core_data = '0;

  logic [1:0]    chan_o, chan2_o;
  logic          int_n, int2_n;
  logic [DW-1:0] bus_data, bus2_data;
  logic          bus_drive, bus2_drive;
  logic          overrun, overrun2;
  logic          sample_err, sample_err2;

  adc_bus_ctrl #(.DATA_W(DW), .NUM_CH(4), .MIN_SH(MS), .COARSE_CYC(CC), .FINE_CYC(FC)) uut (
    .clk(clk), .rst(rst), .mode2(mode2), .cs_n(cs_n), .sh_n(sh_n), .rd_n(rd_n),
    .chsel(chsel), .core_data(core_data), .chan_sel_o(chan_o), .int_n(int_n),
    .bus_data(bus_data), .bus_drive(bus_drive), .overrun(overrun), .sample_err(sample_err));

  adc_bus_ctrl #(.DATA_W(DW), .NUM_CH(2), .MIN_SH(MS), .COARSE_CYC(CC), .FINE_CYC(FC)) uut2 (
    .clk(clk), .rst(rst), .mode2(mode2), .cs_n(cs_n), .sh_n(sh_n), .rd_n(rd_n),
    .chsel(chsel), .core_data(core_data), .chan_sel_o(chan2_o), .int_n(int2_n),
    .bus_data(bus2_data), .bus_drive(bus2_drive), .overrun(overrun2), .sample_err(sample_err2));

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference model, advanced on each rising edge
  int m_st = 0, m_cnt = 0;
  int m_int = 1, m_drv = 0, m_data = 0, m_chan = 0, m_ovr = 0, m_err = 0;
  bit m_psa = 0, m_pra = 0;

  always @(posedge clk) begin
    bit sa, ra, fall, rrise, fin;
    if (rst) begin
      m_st = 0; m_cnt = 0; m_int = 1; m_drv = 0; m_data = 0;
      m_chan = 0; m_ovr = 0; m_err = 0; m_psa = 0; m_pra = 0;
    end else begin
      sa = !cs_n && !sh_n;
      ra = !cs_n && !rd_n;
      fall = sa && !m_psa;
      rrise = !ra && m_pra;
      fin = 0;
      if (fall && m_st != 0) m_ovr = 1;
      if (m_st == 0) begin
        if (fall) begin
          m_chan = chsel;
          if (mode2) begin m_st = 2; m_cnt = 0; end
          else begin m_st = 1; m_cnt = 1; end
        end
      end else if (m_st == 1) begin
        if (sa) m_cnt++;
        else begin
          if (m_cnt < MS) m_err = 1;
          m_st = 3; m_cnt = 0;
        end
      end else if (m_st == 2) begin
        m_cnt++;
        if (m_cnt == CC) begin m_st = 3; m_cnt = 0; end
      end else begin
        m_cnt++;
        if (m_cnt == FC) begin m_st = 0; m_cnt = 0; fin = 1; end
      end
      if (fin) begin m_data = core_data; m_int = 0; end
      else if (rrise) m_int = 1;
      m_drv = ra;
      m_psa = sa;
      m_pra = ra;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R4 R5 R6 int_n vs model", int_n, m_int);
      chk("R7 bus_drive vs model", bus_drive, m_drv);
      chk("R4 R8 bus_data vs model", bus_data, m_data);
      chk("R3 chan_sel_o vs model", chan_o, m_chan);
      chk("R10 overrun vs model", overrun, m_ovr);
      chk("R9 sample_err vs model", sample_err, m_err);
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      fails++;
      $display("FAIL watchdog (all requirements) actual=%0d expected<=%0d", cyc, 20000);
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_int(output int n);
    n = 0;
    for (int i = 0; i < 500; i++) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (!int_n) break;
    end
  endtask

  initial begin
    int n;
    tick(4);
    // R1 reset state
    chk("R1 int_n", int_n, 1);
    chk("R1 bus_drive", bus_drive, 0);
    chk("R1 bus_data", bus_data, 0);
    chk("R1 chan_sel_o", chan_o, 0);
    chk("R1 flags", {overrun, sample_err}, 0);
    rst = 1'b0;
    tick(2);

    // R2 strobes with chip select high
    sh_n = 1'b0; rd_n = 1'b0;
    tick(3);
    chk("R2 bus_drive with cs_n high", bus_drive, 0);
    tick(3);
    sh_n = 1'b1; rd_n = 1'b1;
    tick(FC + CC + 4);
    chk("R2 int_n untouched", int_n, 1);
    chk("R2 no conversion latched", bus_data, 0);

    // R4 strobe-timed conversion on channel 2
    cs_n = 1'b0; chsel = 2'd2; core_data = 10'h2A5;
    sh_n = 1'b0;
    tick(5);
    sh_n = 1'b1;
    wait_int(n);
    chk("R4 edges from release to int_n fall", n, FC + 1);
    chk("R4 result latched", bus_data, 10'h2A5);
    chk("R3 channel 2 captured", chan_o, 2);
    chk("R3 two-channel variant uses low bit", chan2_o, 0);
    chk("R9 long strobe no error", sample_err, 0);

    // R6 R7 read cycle
    rd_n = 1'b0;
    tick(1);
    chk("R7 bus driven after read", bus_drive, 1);
    chk("R6 int_n held during read", int_n, 0);
    rd_n = 1'b1;
    tick(1);
    chk("R6 int_n released after read", int_n, 1);
    chk("R7 bus released after read", bus_drive, 0);

    // R5 R8 read-combined conversion on channel 1
    mode2 = 1'b1; chsel = 2'd1; core_data = 10'h155;
    sh_n = 1'b0; rd_n = 1'b0;
    tick(2);
    chk("R8 bus driven during conversion", bus_drive, 1);
    chk("R8 previous result shown", bus_data, 10'h2A5);
    wait_int(n);
    chk("R5 edges from fall to int_n fall", n + 2, CC + FC + 1);
    chk("R8 new result with int_n fall", bus_data, 10'h155);
    chk("R3 channel 1 captured", chan_o, 1);
    sh_n = 1'b1; rd_n = 1'b1;
    tick(1);
    chk("R6 int_n released by combined strobe", int_n, 1);
    tick(2);

    // R9 short sample strobe, channel 0
    mode2 = 1'b0; chsel = 2'd0; core_data = 10'h0F0;
    sh_n = 1'b0;
    tick(2);
    sh_n = 1'b1;
    wait_int(n);
    chk("R9 sample_err set", sample_err, 1);
    chk("R9 conversion completes", bus_data, 10'h0F0);
    chk("R3 channel 0 captured", chan_o, 0);
    chk("R10 no overrun yet", overrun, 0);
    rd_n = 1'b0; tick(1); rd_n = 1'b1; tick(2);

    // R10 strobe during conversion, channel 3
    chsel = 2'd3; core_data = 10'h3C3;
    sh_n = 1'b0;
    tick(5);
    sh_n = 1'b1;
    tick(3);
    chsel = 2'd0; sh_n = 1'b0;
    tick(1);
    sh_n = 1'b1;
    tick(1);
    wait_int(n);
    chk("R10 completion time unchanged", n + 5, FC + 1);
    chk("R10 overrun set", overrun, 1);
    chk("R10 channel kept", chan_o, 3);
    chk("R3 two-channel variant channel 1", chan2_o, 1);
    chk("R9 sample_err sticky", sample_err, 1);
    rd_n = 1'b0; tick(1); rd_n = 1'b1; tick(3);
    chk("R10 overrun sticky", overrun, 1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule